// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing side of an I2C master. A host reaches it with single-cycle read and write requests on a 32-bit bus. Each register sits at a word-aligned byte offset. The block keeps the settings that a separate bit-timing engine needs: the control bits, the target address, two clock divider values and the receive length. It also holds two byte FIFOs, one in each direction. Both FIFOs are reached through a single data register.

The bit-timing engine draws transmit bytes from the block and hands received bytes back to it. It receives a one-cycle start pulse and reports three outcomes: transfer complete, no acknowledge on the address phase, and no acknowledge on a data byte. The block latches each outcome as a sticky cause bit and raises a level interrupt while any cause is pending and interrupts are enabled. Software clears all causes with one write.

Read responses come back one cycle after the request, on `rsp_valid` and `rsp_rdata`. The register offsets are 0x04 command, 0x0C address high, 0x10 address low, 0x14 standard/fast divider, 0x18 high-speed divider, 0x1C transmit configuration, 0x20 receive configuration, 0x24 data and 0x28 status. Any other offset reads as 0 and ignores writes.

Top module: `i2cm_csr_front`

## Requirements
- R1: After reset every register reads 0, both FIFOs are empty, `eng_start` is low and `irq_o` is low.
- R2: The command register (0x04) stores write-data bits 0 (master enable), 1 (ten-bit address), 3 (interrupt enable), 4 (read direction) and 5 (combined write-then-read). It reads them back in the same positions with all other bits 0, and drives `eng_master_en`, `eng_ten_bit`, `eng_read` and `eng_combined` from them.
- R3: Writing 1 to command bit 6 makes `eng_start` high for exactly the one cycle after the write. A command write with bit 6 clear leaves `eng_start` low. Bit 6 always reads 0.
- R4: The address low register (0x10) keeps write-data bits 6:0 and the address high register (0x0C) keeps bits 2:0. `eng_addr` is {high, low}, 10 bits, and unused bits read 0.
- R5: The standard/fast divider (0x14) and the high-speed divider (0x18) each keep the low DIV_W write-data bits, read them back and drive `eng_div_std` and `eng_div_hs`.
- R6: A write to 0x24 pushes write-data bits 7:0 into the 16-entry transmit FIFO, and a push into a full FIFO is dropped. `eng_tx_valid`/`eng_tx_data` show the oldest byte, and `eng_tx_pop` removes it (ignored when empty).
- R7: A read of 0x24 returns the oldest receive byte in bits 7:0 and removes it. When the receive FIFO is empty the read returns 0 and changes nothing. `eng_rx_push` adds `eng_rx_data` unless the FIFO is full, and `eng_rx_full` flags 16 stored bytes.
- R8: Writing 1 to bit 7 of 0x1C empties the transmit FIFO from the second cycle after the write on. The bit reads back as 0.
- R9: Register 0x20 keeps bits 3:0 as the receive length minus one, read back and driven on `eng_rd_len_m1`. Writing 1 to its bit 7 empties the receive FIFO as in R8, and bit 7 reads 0.
- R10: Status (0x28) bit 0 latches `eng_done`, bit 1 latches `eng_nak_addr` and bit 2 latches `eng_nak_data`. The bits stay set until cleared, bits 6:3 read 0 and bits 6:0 form the cause field.
- R11: A status write with bit 7 set clears all cause bits. A status write with bit 7 clear has no effect. An event arriving in the same cycle as a clear stays latched.
- R12: `irq_o` is high exactly when command bit 3 is set and at least one cause bit is latched.
- R13: Every read request is answered by `rsp_valid` high in the next cycle with the data on `rsp_rdata`. `rsp_valid` is low in the cycle after a write or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| eng_master_en | output | 1 | Master enable to the engine |
| eng_ten_bit | output | 1 | Ten-bit addressing |
| eng_read | output | 1 | Read direction |
| eng_combined | output | 1 | Combined write-then-read |
| eng_start | output | 1 | One-cycle start pulse |
| eng_addr | output | 10 | Target device address |
| eng_div_std | output | DIV_W | Standard/fast divider |
| eng_div_hs | output | DIV_W | High-speed divider |
| eng_rd_len_m1 | output | log2(FIFO_DEPTH) | Receive length minus one |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO full |
| eng_done | input | 1 | Transfer complete event |
| eng_nak_addr | input | 1 | Address not acknowledged event |
| eng_nak_data | input | 1 | Data not acknowledged event |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: FIFO_DEPTH 16, DIV_W 16 and ADDR_W 6. A depth of 16 lets a few dozen bus cycles reach full and empty in both FIFOs. That brings into reach the dropped seventeenth push, the empty read that returns 0 and a refill after an empty read. Sixteen-bit dividers let the bench show that upper write-data bits are discarded. The same build also covers a status clear that collides with a new completion event.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;

  // Word index (byte offset / 4) of each register
  typedef enum logic [3:0] {
    W_CMD     = 4'd1,
    W_ADDR_HI = 4'd3,
    W_ADDR_LO = 4'd4,
    W_DIV_STD = 4'd5,
    W_DIV_HS  = 4'd6,
    W_TX_CFG  = 4'd7,
    W_RX_CFG  = 4'd8,
    W_DATA    = 4'd9,
    W_STATUS  = 4'd10
  } reg_word_e;

  localparam int unsigned CMD_MASTER = 0;
  localparam int unsigned CMD_TENBIT = 1;
  localparam int unsigned CMD_IE     = 3;
  localparam int unsigned CMD_READ   = 4;
  localparam int unsigned CMD_COMB   = 5;
  localparam int unsigned CMD_START  = 6;
  localparam int unsigned CFG_FLUSH  = 7;
  localparam int unsigned ST_CLEAR   = 7;
  localparam int unsigned ST_DONE    = 0;
  localparam int unsigned ST_NAKA    = 1;
  localparam int unsigned ST_NAKD    = 2;
  localparam int unsigned CAUSE_W    = 7;
  localparam int unsigned ADDR_LO_W  = 7;
  localparam int unsigned ADDR_HI_W  = 3;

  typedef struct packed {
    logic combined;
    logic read;
    logic irq_en;
    logic ten_bit;
    logic master_en;
  } ctrl_t;

endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  // DEPTH must be a power of two
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W:0]   wr_q, wr_d, rd_q, rd_d, count_w;
  logic             do_push, do_pop;

  assign count_w = wr_q - rd_q;
  assign empty_o = (wr_q == rd_q);
  assign full_o  = (count_w == (PTR_W+1)'(DEPTH));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign data_o  = mem_q[rd_q[PTR_W-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (flush_i) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + (PTR_W+1)'(1);
      if (do_pop)  rd_d = rd_q + (PTR_W+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q[PTR_W-1:0]] <= data_i;
  end

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_w <= (PTR_W+1)'(DEPTH));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i && !flush_i) |=> empty_o);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);

endmodule

// File: rtl/i2cm_irq_status.sv
module i2cm_irq_status #(
  parameter int unsigned CAUSE_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic [CAUSE_W-1:0] event_i,
  input  logic               irq_en_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;

  // Clear applies first, so an event in the clear cycle survives
  always_comb begin
    cause_d = clear_i ? '0 : cause_q;
    cause_d = cause_d | event_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign irq_o   = irq_en_i & (|cause_q);

  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && event_i == '0) |=> (cause_o == '0));

  p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

endmodule

// File: rtl/i2cm_csr_front.sv
module i2cm_csr_front
  import i2cm_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DIV_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [31:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic                          eng_master_en,
  output logic                          eng_ten_bit,
  output logic                          eng_read,
  output logic                          eng_combined,
  output logic                          eng_start,
  output logic [9:0]                    eng_addr,
  output logic [DIV_W-1:0]              eng_div_std,
  output logic [DIV_W-1:0]              eng_div_hs,
  output logic [$clog2(FIFO_DEPTH)-1:0] eng_rd_len_m1,
  output logic                          eng_tx_valid,
  output logic [7:0]                    eng_tx_data,
  input  logic                          eng_tx_pop,
  input  logic                          eng_rx_push,
  input  logic [7:0]                    eng_rx_data,
  output logic                          eng_rx_full,
  input  logic                          eng_done,
  input  logic                          eng_nak_addr,
  input  logic                          eng_nak_data,
  output logic                          irq_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned LEN_W  = $clog2(FIFO_DEPTH);

  logic [WORD_W-1:0] word_idx;
  logic wr_en, rd_en;
  logic wr_cmd, wr_hi, wr_lo, wr_dstd, wr_dhs, wr_txc, wr_rxc, wr_data, wr_stat, rd_data;

  ctrl_t                ctrl_q, ctrl_d;
  logic                 start_q, start_d;
  logic [ADDR_HI_W-1:0] addr_hi_q, addr_hi_d;
  logic [ADDR_LO_W-1:0] addr_lo_q, addr_lo_d;
  logic [DIV_W-1:0]     dstd_q, dstd_d, dhs_q, dhs_d;
  logic [LEN_W-1:0]     len_q, len_d;
  logic                 txfl_q, txfl_d, rxfl_q, rxfl_d;
  logic                 rsp_v_q, rsp_v_d;
  logic [31:0]          rsp_q, rsp_d, rd_mux;

  logic [7:0]           rx_head;
  logic                 rx_empty, tx_empty;
  logic [CAUSE_W-1:0]   cause, events;
  logic                 unused_bits;

  assign unused_bits = ^{req_wdata, req_addr[1:0]};

  // Request decode
  assign word_idx = req_addr[ADDR_W-1:2];
  assign wr_en    = req_valid & req_write;
  assign rd_en    = req_valid & ~req_write;
  assign wr_cmd   = wr_en & (word_idx == WORD_W'(W_CMD));
  assign wr_hi    = wr_en & (word_idx == WORD_W'(W_ADDR_HI));
  assign wr_lo    = wr_en & (word_idx == WORD_W'(W_ADDR_LO));
  assign wr_dstd  = wr_en & (word_idx == WORD_W'(W_DIV_STD));
  assign wr_dhs   = wr_en & (word_idx == WORD_W'(W_DIV_HS));
  assign wr_txc   = wr_en & (word_idx == WORD_W'(W_TX_CFG));
  assign wr_rxc   = wr_en & (word_idx == WORD_W'(W_RX_CFG));
  assign wr_data  = wr_en & (word_idx == WORD_W'(W_DATA));
  assign wr_stat  = wr_en & (word_idx == WORD_W'(W_STATUS));
  assign rd_data  = rd_en & (word_idx == WORD_W'(W_DATA));

  // Next state
  always_comb begin
    ctrl_d    = ctrl_q;
    addr_hi_d = addr_hi_q;
    addr_lo_d = addr_lo_q;
    dstd_d    = dstd_q;
    dhs_d     = dhs_q;
    len_d     = len_q;
    if (wr_cmd) begin
      ctrl_d.master_en = req_wdata[CMD_MASTER];
      ctrl_d.ten_bit   = req_wdata[CMD_TENBIT];
      ctrl_d.irq_en    = req_wdata[CMD_IE];
      ctrl_d.read      = req_wdata[CMD_READ];
      ctrl_d.combined  = req_wdata[CMD_COMB];
    end
    if (wr_hi)   addr_hi_d = req_wdata[ADDR_HI_W-1:0];
    if (wr_lo)   addr_lo_d = req_wdata[ADDR_LO_W-1:0];
    if (wr_dstd) dstd_d    = req_wdata[DIV_W-1:0];
    if (wr_dhs)  dhs_d     = req_wdata[DIV_W-1:0];
    if (wr_rxc)  len_d     = req_wdata[LEN_W-1:0];
    start_d = wr_cmd & req_wdata[CMD_START];
    txfl_d  = wr_txc & req_wdata[CFG_FLUSH];
    rxfl_d  = wr_rxc & req_wdata[CFG_FLUSH];
    rsp_v_d = rd_en;
    rsp_d   = rd_en ? rd_mux : '0;
  end

  // Read mux
  always_comb begin
    rd_mux = '0;
    case (word_idx)
      WORD_W'(W_CMD): begin
        rd_mux[CMD_MASTER] = ctrl_q.master_en;
        rd_mux[CMD_TENBIT] = ctrl_q.ten_bit;
        rd_mux[CMD_IE]     = ctrl_q.irq_en;
        rd_mux[CMD_READ]   = ctrl_q.read;
        rd_mux[CMD_COMB]   = ctrl_q.combined;
      end
      WORD_W'(W_ADDR_HI): rd_mux[ADDR_HI_W-1:0] = addr_hi_q;
      WORD_W'(W_ADDR_LO): rd_mux[ADDR_LO_W-1:0] = addr_lo_q;
      WORD_W'(W_DIV_STD): rd_mux[DIV_W-1:0]     = dstd_q;
      WORD_W'(W_DIV_HS):  rd_mux[DIV_W-1:0]     = dhs_q;
      WORD_W'(W_RX_CFG):  rd_mux[LEN_W-1:0]     = len_q;
      WORD_W'(W_DATA):    rd_mux[7:0]           = rx_empty ? 8'h00 : rx_head;
      WORD_W'(W_STATUS):  rd_mux[CAUSE_W-1:0]   = cause;
      default:            rd_mux = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      start_q   <= 1'b0;
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      dstd_q    <= '0;
      dhs_q     <= '0;
      len_q     <= '0;
      txfl_q    <= 1'b0;
      rxfl_q    <= 1'b0;
      rsp_v_q   <= 1'b0;
      rsp_q     <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      start_q   <= start_d;
      addr_hi_q <= addr_hi_d;
      addr_lo_q <= addr_lo_d;
      dstd_q    <= dstd_d;
      dhs_q     <= dhs_d;
      len_q     <= len_d;
      txfl_q    <= txfl_d;
      rxfl_q    <= rxfl_d;
      rsp_v_q   <= rsp_v_d;
      rsp_q     <= rsp_d;
    end
  end

  i2cm_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (txfl_q),
    .push_i  (wr_data),
    .data_i  (req_wdata[7:0]),
    .pop_i   (eng_tx_pop),
    .data_o  (eng_tx_data),
    .empty_o (tx_empty),
    .full_o  ()
  );

  i2cm_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (rxfl_q),
    .push_i  (eng_rx_push),
    .data_i  (eng_rx_data),
    .pop_i   (rd_data),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (eng_rx_full)
  );

  always_comb begin
    events          = '0;
    events[ST_DONE] = eng_done;
    events[ST_NAKA] = eng_nak_addr;
    events[ST_NAKD] = eng_nak_data;
  end

  i2cm_irq_status #(.CAUSE_W(CAUSE_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (wr_stat & req_wdata[ST_CLEAR]),
    .event_i  (events),
    .irq_en_i (ctrl_q.irq_en),
    .cause_o  (cause),
    .irq_o    (irq_o)
  );

  assign eng_master_en = ctrl_q.master_en;
  assign eng_ten_bit   = ctrl_q.ten_bit;
  assign eng_read      = ctrl_q.read;
  assign eng_combined  = ctrl_q.combined;
  assign eng_start     = start_q;
  assign eng_addr      = {addr_hi_q, addr_lo_q};
  assign eng_div_std   = dstd_q;
  assign eng_div_hs    = dhs_q;
  assign eng_rd_len_m1 = len_q;
  assign eng_tx_valid  = ~tx_empty;
  assign rsp_valid     = rsp_v_q;
  assign rsp_rdata     = rsp_q;

  p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && word_idx == WORD_W'(W_CMD) && !req_wdata[CMD_START])
      |=> !eng_start);

  p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && word_idx == WORD_W'(W_TX_CFG) && req_wdata[CFG_FLUSH])
      |=> ##1 !eng_tx_valid);

endmodule

// File: tb/i2cm_csr_front_tb_top.sv
module i2cm_csr_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        eng_master_en, eng_ten_bit, eng_read, eng_combined, eng_start;
  logic [9:0]  eng_addr;
  logic [15:0] eng_div_std, eng_div_hs;
  logic [3:0]  eng_rd_len_m1;
  logic        eng_tx_valid, eng_rx_full;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_done = 0, eng_nak_addr = 0, eng_nak_data = 0;
  logic        irq_o;

  always #2.5 clk = ~clk;

  i2cm_csr_front dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .eng_master_en(eng_master_en), .eng_ten_bit(eng_ten_bit), .eng_read(eng_read),
    .eng_combined(eng_combined), .eng_start(eng_start), .eng_addr(eng_addr),
    .eng_div_std(eng_div_std), .eng_div_hs(eng_div_hs), .eng_rd_len_m1(eng_rd_len_m1),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
    .eng_done(eng_done), .eng_nak_addr(eng_nak_addr), .eng_nak_data(eng_nak_data),
    .irq_o(irq_o)
  );

  // Reference model state
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [6:0]  m_cmd = '0;
  logic        m_start = 0;
  logic [2:0]  m_hi = '0;
  logic [6:0]  m_lo = '0;
  logic [15:0] m_dstd = '0, m_dhs = '0;
  logic [3:0]  m_len = '0;
  logic [6:0]  m_cause = '0;
  logic        pend_txfl = 0, pend_rxfl = 0;
  bit          cmp_on = 0;
  bit          finished = 0;
  int          checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of the engine-side outputs
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R12 irq_o", 64'(irq_o), 64'(m_cmd[3] & (|m_cause)));
      chk("R3 eng_start", 64'(eng_start), 64'(m_start));
      chk("R2 control outputs", 64'({eng_combined, eng_read, eng_ten_bit, eng_master_en}),
          64'({m_cmd[5], m_cmd[4], m_cmd[1], m_cmd[0]}));
      chk("R4 eng_addr", 64'(eng_addr), 64'({m_hi, m_lo}));
      chk("R5 eng_div_std", 64'(eng_div_std), 64'(m_dstd));
      chk("R5 eng_div_hs", 64'(eng_div_hs), 64'(m_dhs));
      chk("R9 eng_rd_len_m1", 64'(eng_rd_len_m1), 64'(m_len));
      chk("R6 eng_tx_valid", 64'(eng_tx_valid), 64'(txq.size() > 0));
      if (txq.size() > 0) chk("R6 eng_tx_data", 64'(eng_tx_data), 64'(txq[0]));
      chk("R7 eng_rx_full", 64'(eng_rx_full), 64'(rxq.size() == 16));
    end
  end

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    case (a)
      6'h04: return 32'(m_cmd);
      6'h0C: return 32'(m_hi);
      6'h10: return 32'(m_lo);
      6'h14: return 32'(m_dstd);
      6'h18: return 32'(m_dhs);
      6'h20: return 32'(m_len);
      6'h24: return (rxq.size() > 0) ? 32'(rxq[0]) : 32'h0;
      6'h28: return 32'(m_cause);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [5:0] a, input logic [31:0] d);
    case (a)
      6'h04: begin m_cmd = d[6:0] & 7'h3B; m_start = d[6]; end
      6'h0C: m_hi = d[2:0];
      6'h10: m_lo = d[6:0];
      6'h14: m_dstd = d[15:0];
      6'h18: m_dhs = d[15:0];
      6'h1C: pend_txfl = d[7];
      6'h20: begin m_len = d[3:0]; pend_rxfl = d[7]; end
      6'h24: if (txq.size() < 16) txq.push_back(d[7:0]);
      6'h28: if (d[7]) m_cause = '0;
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    model_wr(a, d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    @(posedge clk); #1;
    chk("R13 no response after write", 64'(rsp_valid), 64'h0);
    m_start = 0;
    if (pend_txfl) begin txq.delete(); pend_txfl = 0; end
    if (pend_rxfl) begin rxq.delete(); pend_rxfl = 0; end
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    logic [31:0] exp;
    exp = model_rd(a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    chk("R13 rsp_valid", 64'(rsp_valid), 64'h1);
    chk(tag, 64'(rsp_rdata), 64'(exp));
    if (a == 6'h24 && rxq.size() > 0) void'(rxq.pop_front());
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic tx_pop();
    @(negedge clk); eng_tx_pop = 1;
    @(posedge clk); #1;
    if (txq.size() > 0) void'(txq.pop_front());
    @(negedge clk); eng_tx_pop = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
    @(posedge clk); #1;
    if (rxq.size() < 16) rxq.push_back(b);
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic eng_ev(input logic d, input logic na, input logic nd);
    @(negedge clk); eng_done = d; eng_nak_addr = na; eng_nak_data = nd;
    @(posedge clk); #1;
    m_cause = m_cause | {4'b0, nd, na, d};
    @(negedge clk); eng_done = 0; eng_nak_addr = 0; eng_nak_data = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    cmp_on = 1;

    // R1: reset values
    foreach (txq[i]) ;
    rd_chk(6'h04, "R1 reset cmd");
    rd_chk(6'h0C, "R1 reset addr hi");
    rd_chk(6'h10, "R1 reset addr lo");
    rd_chk(6'h14, "R1 reset div std");
    rd_chk(6'h18, "R1 reset div hs");
    rd_chk(6'h1C, "R1 reset tx cfg");
    rd_chk(6'h20, "R1 reset rx cfg");
    rd_chk(6'h24, "R1 reset data");
    rd_chk(6'h28, "R1 reset status");
    chk("R1 irq after reset", 64'(irq_o), 64'h0);

    // R2 / R3: command register and start pulse
    bus_wr(6'h04, 32'hFFFF_FFBF);
    rd_chk(6'h04, "R2 cmd readback");
    bus_wr(6'h04, 32'h0000_0059);
    rd_chk(6'h04, "R3 start bit reads 0");
    bus_wr(6'h04, 32'h0000_0019);
    chk("R3 no pulse without bit 6", 64'(eng_start), 64'h0);

    // R4: address
    bus_wr(6'h10, 32'hFFFF_FFD5);
    bus_wr(6'h0C, 32'hFFFF_FFFE);
    rd_chk(6'h10, "R4 addr lo");
    rd_chk(6'h0C, "R4 addr hi");

    // R5: dividers
    bus_wr(6'h14, 32'hDEAD_1234);
    bus_wr(6'h18, 32'h5555_ABCD);
    rd_chk(6'h14, "R5 div std");
    rd_chk(6'h18, "R5 div hs");

    // R6: transmit FIFO ordering and overflow
    bus_wr(6'h24, 32'hFFFF_FFA1);
    bus_wr(6'h24, 32'h0000_00B2);
    bus_wr(6'h24, 32'h0000_01C3);
    tx_pop();
    tx_pop();
    for (int i = 0; i < 17; i++) bus_wr(6'h24, 32'(8'h40 + i));
    chk("R6 tx depth after overflow", 64'(txq.size()), 64'd16);
    for (int i = 0; i < 17; i++) tx_pop();
    chk("R6 tx empty after drain", 64'(eng_tx_valid), 64'h0);

    // R8: transmit flush
    for (int i = 0; i < 5; i++) bus_wr(6'h24, 32'(8'h70 + i));
    bus_wr(6'h1C, 32'h0000_008F);
    chk("R8 tx empty after flush", 64'(eng_tx_valid), 64'h0);
    rd_chk(6'h1C, "R8 tx cfg reads 0");

    // R7: receive FIFO
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    rd_chk(6'h24, "R7 rx byte 1");
    rd_chk(6'h24, "R7 rx byte 2");
    rd_chk(6'h24, "R7 rx byte 3");
    rd_chk(6'h24, "R7 empty read returns 0");
    rx_push(8'h44);
    rd_chk(6'h24, "R7 byte after empty read");
    for (int i = 0; i < 17; i++) rx_push(8'h80 + 8'(i));
    chk("R7 rx full", 64'(eng_rx_full), 64'h1);
    rd_chk(6'h24, "R7 oldest after overflow");

    // R9: receive config
    bus_wr(6'h20, 32'h0000_000F);
    rd_chk(6'h20, "R9 length readback");
    bus_wr(6'h20, 32'h0000_0083);
    rd_chk(6'h20, "R9 length with flush");
    rd_chk(6'h24, "R9 rx empty after flush");

    // R10 / R11 / R12: status and interrupt
    eng_ev(1, 0, 0);
    rd_chk(6'h28, "R10 done latched");
    eng_ev(0, 1, 0);
    rd_chk(6'h28, "R10 addr nak latched");
    bus_wr(6'h28, 32'h0000_007F);
    rd_chk(6'h28, "R11 write without bit 7 ignored");
    bus_wr(6'h28, 32'h0000_0080);
    rd_chk(6'h28, "R11 cleared");
    eng_ev(0, 0, 1);
    rd_chk(6'h28, "R10 data nak latched");
    bus_wr(6'h04, 32'h0000_0011);
    chk("R12 irq masked", 64'(irq_o), 64'h0);
    bus_wr(6'h04, 32'h0000_0019);
    chk("R12 irq enabled", 64'(irq_o), 64'h1);

    // R11: clear and event in the same cycle
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 6'h28; req_wdata = 32'h80; eng_done = 1;
    @(posedge clk); #1;
    m_cause = 7'h01;
    @(negedge clk);
    req_valid = 0; req_write = 0; eng_done = 0;
    rd_chk(6'h28, "R11 event wins over clear");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule